// File: doc/BRIEF.md
# Tiled Memory Access Port Front End

This block is the register face of a memory access port that sits in front of a single-command debug bridge. A requester addresses one word register at a time: a control word holding the transfer size and the auto-increment mode, a transfer address, a data window that walks forward through memory, four banked data windows covering an aligned 16-byte group, and three read-only identity registers. Local registers answer at once. The data windows each turn into exactly one bridge command.

Before a command is issued, the port address is moved into the bridge's space. The debug ROM base is subtracted first. Offsets that fall below the root span go to tile 0 unchanged. Any higher offset has the root span removed and is then split into equal power-of-two tile windows, with tile numbers starting at 1. The auto-increment lives in its own offset register next to the transfer address, so rewriting the address sets the walk back to its start.

Errors come from three sources: a write issued while a non-zero bank is selected, an access to an undecoded register, and a bridge failure. Each one is reported on its own response and also sets a sticky flag. A separate run request reads that flag and clears it.

Top module: `tmap_front`

## Requirements
- R1: A port address whose offset from 0x80000000 (modulo 2^32) is below 0x44000000 is sent to the bridge as tile 0, with that offset as the local address.
- R2: Any other offset has 0x44000000 subtracted. The tile is that value divided by 0x04000000, plus 1. The local address is the remainder modulo 0x04000000.
- R3: A write to the transfer-address register (offset 0x04) stores the value and sets the increment offset to zero. A data-window access (offset 0x0C) targets the transfer address with bits 1:0 cleared, plus the increment offset.
- R4: After a data-window access completes without bridge error, and only when control-word bits 5:4 are non-zero, the increment offset grows by twice control-word bits 1:0. With bits 5:4 at zero, or after a bridge error, it stays unchanged.
- R5: A banked access at offset 0x10, 0x14, 0x18 or 0x1C targets the transfer address with bits 3:0 cleared, plus 4 times the offset bits 3:2. The increment offset has no effect on it.
- R6: Reads of offset 0xF8 return 0x80000000. Reads of offset 0xF4 return 0. Reads of offset 0xFC return 0x44770002 when the port number is 0 and 0 for any other port. Writes to these three offsets are errors.
- R7: A write while the bank input is non-zero responds with the error flag set and changes no register.
- R8: Every error response sets a sticky flag. One cycle after a run request, run_done is high and run_err carries the flag, and the flag is then cleared.
- R9: An access to an undecoded offset responds one cycle after acceptance, with the error flag set and no bridge command.
- R10: A bridge command stays valid with stable fields until br_done. rsp_ready stays low until then and rises one cycle later, with br_rdata and br_err forwarded as the response.
- R11: The control word (offset 0x00) reads back the value last written to it, and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Register request, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 8 | Register byte offset |
| req_bank | input | 4 | Selected register bank |
| req_port | input | 8 | Access port number |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error for this response |
| run_req | input | 1 | Report and clear the sticky error |
| run_done | output | 1 | Run acknowledge |
| run_err | output | 1 | Sticky error value at the run request |
| br_valid | output | 1 | Bridge command valid |
| br_write | output | 1 | Bridge command is a write |
| br_tile | output | 6 | Target tile |
| br_addr | output | 32 | Tile-local byte address |
| br_wdata | output | 32 | Bridge write data |
| br_done | input | 1 | Bridge command complete (one cycle) |
| br_rdata | input | 32 | Bridge read data |
| br_err | input | 1 | Bridge command failed |

## Verification
The checks assume that the requester keeps req_valid and its fields steady until rsp_ready, and that br_done comes only while br_valid is high and lasts one cycle. They also assume run_req is never raised in the same cycle that an error response is formed. The bench performs each access as a single blocking transaction: it drops the request on the strobe, answers the bridge only while a command is pending, and issues run requests only between transactions. As a result, every input sequence it produces stays inside these assumptions.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
  localparam int unsigned SEL_W = 8;

  localparam logic [SEL_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [SEL_W-1:0] OFS_XADR = 8'h04;
  localparam logic [SEL_W-1:0] OFS_WIN  = 8'h0C;
  localparam logic [SEL_W-1:0] OFS_GRP0 = 8'h10;
  localparam logic [SEL_W-1:0] OFS_GRP1 = 8'h14;
  localparam logic [SEL_W-1:0] OFS_GRP2 = 8'h18;
  localparam logic [SEL_W-1:0] OFS_GRP3 = 8'h1C;
  localparam logic [SEL_W-1:0] OFS_CFG  = 8'hF4;
  localparam logic [SEL_W-1:0] OFS_BASE = 8'hF8;
  localparam logic [SEL_W-1:0] OFS_IDR  = 8'hFC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } tmap_state_e;
endpackage

// File: rtl/tmap_addr_gen.sv
module tmap_addr_gen #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] tar_i,
  input  logic [AW-1:0] inc_i,
  input  logic          grp_sel_i,
  input  logic [1:0]    grp_idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] win_addr;
  logic [AW-1:0] grp_addr;

  always_comb begin
    win_addr = {tar_i[AW-1:2], 2'b00} + inc_i;
    grp_addr = {tar_i[AW-1:4], 4'b0000} + {{(AW-4){1'b0}}, grp_idx_i, 2'b00};
    addr_o   = grp_sel_i ? grp_addr : win_addr;
  end
endmodule

// File: rtl/tmap_xlate.sv
module tmap_xlate #(
  parameter int unsigned AW         = 32,
  parameter int unsigned TILE_W     = 6,
  parameter int unsigned TILE_SHIFT = 26,
  parameter logic [AW-1:0] ROM_BASE  = 32'h8000_0000,
  parameter logic [AW-1:0] ROOT_SPAN = 32'h4400_0000
) (
  input  logic [AW-1:0]     addr_i,
  output logic [TILE_W-1:0] tile_o,
  output logic [AW-1:0]     local_o
);
  localparam logic [AW-1:0] LOCAL_MASK = (AW'(1) << TILE_SHIFT) - AW'(1);

  logic [AW-1:0] rel;
  logic [AW-1:0] tail;

  always_comb begin
    rel  = addr_i - ROM_BASE;
    tail = rel - ROOT_SPAN;
    if (rel < ROOT_SPAN) begin
      tile_o  = '0;
      local_o = rel;
    end else begin
      tile_o  = TILE_W'(tail >> TILE_SHIFT) + TILE_W'(1);
      local_o = tail & LOCAL_MASK;
    end
  end
endmodule

// File: rtl/tmap_front.sv
module tmap_front
  import tmap_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned TILE_W     = 6,
  parameter int unsigned TILE_SHIFT = 26,
  parameter logic [AW-1:0] ROM_BASE  = 32'h8000_0000,
  parameter logic [AW-1:0] ROOT_SPAN = 32'h4400_0000,
  parameter logic [DW-1:0] ID_VALUE  = 32'h4477_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PORT_W-1:0] req_port,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  input  logic              run_req,
  output logic              run_done,
  output logic              run_err,
  output logic              br_valid,
  output logic              br_write,
  output logic [TILE_W-1:0] br_tile,
  output logic [AW-1:0]     br_addr,
  output logic [DW-1:0]     br_wdata,
  input  logic              br_done,
  input  logic [DW-1:0]     br_rdata,
  input  logic              br_err
);
  // reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  tmap_state_e st_q, st_d;
  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] xadr_q, inc_q, inc_d;
  logic          ctrl_en, xadr_en, inc_en, br_en, rsp_en;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic          rsp_err_q, rsp_err_d;
  logic          win_q;
  logic          sticky_q, sticky_d, new_err;
  logic          run_done_q, run_err_q;
  logic          br_write_q;
  logic [TILE_W-1:0] br_tile_q;
  logic [AW-1:0] br_addr_q;
  logic [DW-1:0] br_wdata_q;

  logic          grp_sel;
  logic [AW-1:0] port_addr;
  logic [TILE_W-1:0] x_tile;
  logic [AW-1:0] x_local;

  assign grp_sel = (req_sel[SEL_W-1:4] == 4'h1) && (req_sel[1:0] == 2'b00);

  tmap_addr_gen #(.AW(AW)) u_agen (
    .tar_i     (xadr_q),
    .inc_i     (inc_q),
    .grp_sel_i (grp_sel),
    .grp_idx_i (req_sel[3:2]),
    .addr_o    (port_addr)
  );

  tmap_xlate #(
    .AW(AW), .TILE_W(TILE_W), .TILE_SHIFT(TILE_SHIFT),
    .ROM_BASE(ROM_BASE), .ROOT_SPAN(ROOT_SPAN)
  ) u_xlate (
    .addr_i  (port_addr),
    .tile_o  (x_tile),
    .local_o (x_local)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    ctrl_en    = 1'b0;
    xadr_en    = 1'b0;
    inc_en     = 1'b0;
    inc_d      = inc_q;
    br_en      = 1'b0;
    rsp_en     = 1'b0;
    rsp_data_d = rsp_data_q;
    rsp_err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d       = ST_RESP;
          rsp_en     = 1'b1;
          rsp_data_d = '0;
          if (req_write && (req_bank != '0)) begin
            rsp_err_d = 1'b1;
          end else begin
            case (req_sel)
              OFS_CTRL: begin
                if (req_write) ctrl_en = 1'b1;
                else           rsp_data_d = ctrl_q;
              end
              OFS_XADR: begin
                if (req_write) begin
                  xadr_en = 1'b1;
                  inc_en  = 1'b1;
                  inc_d   = '0;
                end else begin
                  rsp_data_d = DW'(xadr_q);
                end
              end
              OFS_WIN, OFS_GRP0, OFS_GRP1, OFS_GRP2, OFS_GRP3: begin
                st_d   = ST_BUSY;
                br_en  = 1'b1;
                rsp_en = 1'b0;
              end
              OFS_CFG: begin
                if (req_write) rsp_err_d = 1'b1;
              end
              OFS_BASE: begin
                if (req_write) rsp_err_d = 1'b1;
                else           rsp_data_d = DW'(ROM_BASE);
              end
              OFS_IDR: begin
                if (req_write)            rsp_err_d = 1'b1;
                else if (req_port == '0)  rsp_data_d = ID_VALUE;
              end
              default: rsp_err_d = 1'b1;
            endcase
          end
        end
      end
      ST_BUSY: begin
        if (br_done) begin
          st_d       = ST_RESP;
          rsp_en     = 1'b1;
          rsp_data_d = br_rdata;
          rsp_err_d  = br_err;
          if (win_q && !br_err && (ctrl_q[5:4] != 2'b00)) begin
            inc_en = 1'b1;
            inc_d  = inc_q + {{(AW-3){1'b0}}, ctrl_q[1:0], 1'b0};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    new_err  = rsp_en & rsp_err_d;
    sticky_d = (sticky_q & ~run_req) | new_err;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q       <= ST_IDLE;
      ctrl_q     <= '0;
      xadr_q     <= '0;
      inc_q      <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
      win_q      <= 1'b0;
      sticky_q   <= 1'b0;
      run_done_q <= 1'b0;
      run_err_q  <= 1'b0;
      br_write_q <= 1'b0;
      br_tile_q  <= '0;
      br_addr_q  <= '0;
      br_wdata_q <= '0;
    end else begin
      st_q       <= st_d;
      sticky_q   <= sticky_d;
      run_done_q <= run_req;
      run_err_q  <= run_req & sticky_q;
      if (ctrl_en) ctrl_q <= req_wdata;
      if (xadr_en) xadr_q <= AW'(req_wdata);
      if (inc_en)  inc_q  <= inc_d;
      if (rsp_en) begin
        rsp_data_q <= rsp_data_d;
        rsp_err_q  <= rsp_err_d;
      end
      if (br_en) begin
        win_q      <= (req_sel == OFS_WIN);
        br_write_q <= req_write;
        br_tile_q  <= x_tile;
        br_addr_q  <= x_local;
        br_wdata_q <= req_wdata;
      end
    end
  end

  assign rsp_ready = (st_q == ST_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_err   = rsp_err_q & rsp_ready;
  assign run_done  = run_done_q;
  assign run_err   = run_err_q;
  assign br_valid  = (st_q == ST_BUSY);
  assign br_write  = br_write_q;
  assign br_tile   = br_tile_q;
  assign br_addr   = br_addr_q;
  assign br_wdata  = br_wdata_q;
endmodule

// File: rtl/tmap_front_chk.sv
module tmap_front_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned TILE_W     = 6,
  parameter int unsigned TILE_SHIFT = 26,
  parameter logic [AW-1:0] ROOT_SPAN = 32'h4400_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_ready,
  input logic              run_req,
  input logic              run_done,
  input logic              br_valid,
  input logic              br_done,
  input logic [TILE_W-1:0] br_tile,
  input logic [AW-1:0]     br_addr
);
  AST_ROOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_tile == '0) |-> (br_addr < ROOT_SPAN)); // R1

  AST_TILE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_tile != '0) |-> ((br_addr >> TILE_SHIFT) == '0)); // R2

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_done) |=> (br_valid && $stable(br_addr) && $stable(br_tile))); // R10

  AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_done) |=> rsp_ready); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready); // R10

  AST_RUN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |=> run_done); // R8
endmodule

bind tmap_front tmap_front_chk #(
  .AW(AW), .TILE_W(TILE_W), .TILE_SHIFT(TILE_SHIFT), .ROOT_SPAN(ROOT_SPAN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_ready (rsp_ready),
  .run_req   (run_req),
  .run_done  (run_done),
  .br_valid  (br_valid),
  .br_done   (br_done),
  .br_tile   (br_tile),
  .br_addr   (br_addr)
);

// File: tb/tb_tmap_front.sv
`timescale 1ns/1ps
module tb_tmap_front;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [7:0] req_sel;
  logic [3:0] req_bank;
  logic [7:0] req_port;
  logic [31:0] req_wdata;
  logic rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic run_req, run_done, run_err;
  logic br_valid, br_write;
  logic [5:0] br_tile;
  logic [31:0] br_addr, br_wdata;
  logic br_done, br_err;
  logic [31:0] br_rdata;

  always #4 clk = ~clk;

  tmap_front dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_bank(req_bank), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .run_req(run_req), .run_done(run_done), .run_err(run_err),
    .br_valid(br_valid), .br_write(br_write), .br_tile(br_tile),
    .br_addr(br_addr), .br_wdata(br_wdata),
    .br_done(br_done), .br_rdata(br_rdata), .br_err(br_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  // results of the last transaction
  logic        r_got_br, r_bwr, r_err, r_hold_ok;
  logic [5:0]  r_tile;
  logic [31:0] r_addr, r_bwd, r_rdata;
  int          r_cycles;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] sel, input logic [3:0] bank,
                        input logic [7:0] port, input logic [31:0] wd,
                        input logic [31:0] bdata, input logic berr, input int lat);
    int seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_bank = bank;
    req_port = port; req_wdata = wd;
    r_got_br = 1'b0; r_hold_ok = 1'b1; r_cycles = 0;
    forever begin
      @(negedge clk);
      r_cycles++;
      br_done = 1'b0;
      if (rsp_ready) begin
        r_rdata = rsp_rdata; r_err = rsp_err;
        req_valid = 1'b0;
        break;
      end
      if (br_valid) begin
        if (!r_got_br) begin
          r_tile = br_tile; r_addr = br_addr; r_bwr = br_write; r_bwd = br_wdata;
        end else if (br_tile != r_tile || br_addr != r_addr) begin
          r_hold_ok = 1'b0;
        end
        r_got_br = 1'b1;
        seen++;
        if (seen > lat) begin
          br_done = 1'b1; br_rdata = bdata; br_err = berr;
        end
      end
      if (r_cycles > 200) begin
        chk(1'b0, "R10 transaction hang", 64'(r_cycles), 64'd200);
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wreg(input logic [7:0] sel, input logic [31:0] d);
    access(1'b1, sel, 4'd0, 8'd0, d, 32'd0, 1'b0, 0);
  endtask

  task automatic run_flush(input logic exp, input string tag);
    @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    run_req = 1'b0;
    chk(run_done && run_err == exp, tag, {62'd0, run_done, run_err}, {62'd0, 1'b1, exp});
  endtask

  function automatic void model(input logic [31:0] pa, output logic [5:0] t, output logic [31:0] la);
    logic [31:0] rel;
    logic [31:0] tl;
    rel = pa - 32'h8000_0000;
    if (rel < 32'h4400_0000) begin
      t = 6'd0; la = rel;
    end else begin
      tl = rel - 32'h4400_0000;
      t  = 6'(tl / 32'h0400_0000 + 32'd1);
      la = tl % 32'h0400_0000;
    end
  endfunction

  task automatic map_check(input logic [31:0] tar, input string tag);
    logic [5:0]  et;
    logic [31:0] ea;
    logic [31:0] pat;
    model(tar & ~32'h3, et, ea);
    pat = tar ^ 32'h5A5A_0000;
    wreg(8'h04, tar);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, pat, 1'b0, 0);
    chk(r_got_br && r_tile == et, {tag, " tile"}, 64'(r_tile), 64'(et));
    chk(r_addr == ea, {tag, " local address"}, 64'(r_addr), 64'(ea));
    chk(r_rdata == pat && !r_err && !r_bwr, {tag, " read data"}, 64'(r_rdata), 64'(pat));
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_sel = '0; req_bank = '0;
    req_port = '0; req_wdata = '0; run_req = 1'b0;
    br_done = 1'b0; br_rdata = '0; br_err = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rsp_ready && !br_valid && !run_done, "R10 reset outputs idle",
        {61'd0, rsp_ready, br_valid, run_done}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 control word reset value and readback
    access(1'b0, 8'h00, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'd0 && !r_err, "R11 control word after reset", 64'(r_rdata), 64'd0);
    wreg(8'h00, 32'h0000_0A31);
    access(1'b0, 8'h00, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'h0000_0A31, "R11 control word readback", 64'(r_rdata), 64'h0A31);
    wreg(8'h00, 32'h0);
    run_flush(1'b0, "R8 no error after clean traffic");

    // R6 identity registers
    access(1'b0, 8'hF8, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'h8000_0000 && !r_got_br, "R6 base register", 64'(r_rdata), 64'h8000_0000);
    access(1'b0, 8'hF4, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'd0 && !r_err, "R6 config register", 64'(r_rdata), 64'd0);
    access(1'b0, 8'hFC, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'h4477_0002, "R6 id register port 0", 64'(r_rdata), 64'h4477_0002);
    access(1'b0, 8'hFC, 4'd0, 8'd3, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'd0, "R6 id register port 3", 64'(r_rdata), 64'd0);
    access(1'b1, 8'hF8, 4'd0, 8'd0, 32'h1, 32'd0, 1'b0, 0);
    chk(r_err && !r_got_br, "R6 write to base register fails", 64'(r_err), 64'd1);
    run_flush(1'b1, "R8 sticky after fixed-register write");
    run_flush(1'b0, "R8 sticky cleared by run");

    // R1 R2 tile sweep over every reachable tile
    for (int i = 0; i < 48; i++) begin
      logic [31:0] pa;
      if (i == 0) pa = 32'h80AB_CDE3;
      else pa = 32'hC400_0000 + 32'(i - 1) * 32'h0400_0000 + 32'h0012_3457;
      map_check(pa, (i == 0) ? "R1 root sweep" : "R2 tile sweep");
    end
    map_check(32'hC3FF_FFFC, "R1 last root word");
    map_check(32'h8000_0000, "R1 first root word");
    map_check(32'hC400_0000, "R2 first tile-1 word");
    map_check(32'h0000_0000, "R2 wrapped address");
    map_check(32'h7FFF_FFFC, "R2 highest tile");

    // R3 R4 increment walk for each size
    for (int s = 0; s < 3; s++) begin
      wreg(8'h00, 32'h10 | 32'(s));
      wreg(8'h04, 32'h8000_0102);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] ea;
        ea = 32'h100 + 32'(k * 2 * s);
        access(1'b1, 8'h0C, 4'd0, 8'd0, 32'hD000_0000 + 32'(k), 32'd0, 1'b0, 0);
        chk(r_tile == 6'd0 && r_addr == ea, "R4 increment walk address", 64'(r_addr), 64'(ea));
        chk(r_bwr && r_bwd == 32'hD000_0000 + 32'(k) && !r_err, "R3 window write data",
            64'(r_bwd), 64'(32'hD000_0000 + 32'(k)));
      end
    end
    wreg(8'h04, 32'h8000_0102);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_addr == 32'h100, "R3 address rewrite resets offset", 64'(r_addr), 64'h100);
    wreg(8'h00, 32'h2);
    wreg(8'h04, 32'h8000_0100);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_addr == 32'h100, "R4 no growth with increment mode off", 64'(r_addr), 64'h100);

    // R4 R8 bridge error
    wreg(8'h00, 32'h12);
    wreg(8'h04, 32'h8000_0100);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'hBAD0_0001, 1'b1, 0);
    chk(r_err && r_rdata == 32'hBAD0_0001, "R10 bridge error forwarded", 64'(r_err), 64'd1);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_addr == 32'h100, "R4 no growth after bridge error", 64'(r_addr), 64'h100);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_addr == 32'h104, "R4 growth resumes after success", 64'(r_addr), 64'h104);
    run_flush(1'b1, "R8 sticky after bridge error");
    run_flush(1'b0, "R8 sticky cleared after bridge error");

    // R5 banked group windows, offset ignored
    wreg(8'h00, 32'h12);
    wreg(8'h04, 32'h8000_123C);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    for (int n = 0; n < 4; n++) begin
      logic [31:0] ea;
      ea = 32'h1230 + 32'(4 * n);
      access(n[0], 8'h10 + 8'(4 * n), 4'd0, 8'd0, 32'hB0 + 32'(n), 32'hC0 + 32'(n), 1'b0, 0);
      chk(r_addr == ea && r_tile == 6'd0, "R5 group address", 64'(r_addr), 64'(ea));
      chk(r_bwr == n[0] && r_rdata == 32'hC0 + 32'(n), "R5 group direction and data",
          64'(r_rdata), 64'(32'hC0 + 32'(n)));
    end
    wreg(8'h04, 32'hC800_0018);
    access(1'b0, 8'h14, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_tile == 6'd2 && r_addr == 32'h14, "R5 group address in tile 2",
        {26'd0, r_tile, r_addr}, {26'd0, 6'd2, 32'h14});

    // R7 bank non-zero writes
    wreg(8'h00, 32'h21);
    access(1'b1, 8'h00, 4'd1, 8'd0, 32'hFFFF_FFFF, 32'd0, 1'b0, 0);
    chk(r_err && !r_got_br, "R7 banked write rejected", 64'(r_err), 64'd1);
    access(1'b0, 8'h00, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_rdata == 32'h21, "R7 control word unchanged", 64'(r_rdata), 64'h21);
    wreg(8'h04, 32'h8000_0040);
    access(1'b1, 8'h04, 4'd2, 8'd0, 32'h8000_0800, 32'd0, 1'b0, 0);
    access(1'b1, 8'h0C, 4'd3, 8'd0, 32'h1, 32'd0, 1'b0, 0);
    chk(r_err && !r_got_br, "R7 banked window write issues no command", 64'(r_got_br), 64'd0);
    access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_addr == 32'h40, "R7 address register unchanged", 64'(r_addr), 64'h40);
    run_flush(1'b1, "R8 sticky after banked write");
    run_flush(1'b0, "R8 sticky cleared after banked write");

    // R9 undecoded offsets
    access(1'b0, 8'h40, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_err && !r_got_br && r_cycles == 1, "R9 undecoded read", 64'(r_cycles), 64'd1);
    access(1'b1, 8'h11, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 0);
    chk(r_err && !r_got_br && r_cycles == 1, "R9 misaligned group write", 64'(r_got_br), 64'd0);
    run_flush(1'b1, "R8 sticky after undecoded access");

    // R10 bridge latency
    for (int lat = 0; lat < 7; lat += 3) begin
      access(1'b0, 8'h0C, 4'd0, 8'd0, 32'd0, 32'h7700_0000 + 32'(lat), 1'b0, lat);
      chk(r_cycles == 2 + lat && r_hold_ok, "R10 ready waits for bridge",
          64'(r_cycles), 64'(2 + lat));
      chk(r_rdata == 32'h7700_0000 + 32'(lat) && !r_err, "R10 read data forwarded",
          64'(r_rdata), 64'(32'h7700_0000 + 32'(lat)));
    end
    run_flush(1'b0, "R8 clean after latency tests");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule